// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter with a parallel preset, an active-low clear and two count enables. Every flip-flop is clocked together on the rising edge of one shared clock. The stage is 4 bits wide by default. Longer counters are built by chaining stages on one clock. Each stage's carry output drives the carry-chain enable of the next stage, and no extra gating is needed.

A parameter picks the clear behaviour. In asynchronous mode the count drops to zero as soon as clear goes low. In synchronous mode clear takes effect at the next rising edge. The synchronous mode lets a decoded count value, fed back to clear, shorten the count length. For example, decoding 9 gives a divide-by-ten stage.

At a clock edge the actions rank as follows: clear first, then load, then count, then hold. The carry output is combinational and is not registered. It is derived from the current count and the carry-chain enable.

Top module: `casc_counter`

## Requirements
- R1: The count register changes only on a rising clock edge, with all bits updating in the same edge. The one exception is the asynchronous clear of R2.
- R2: With ASYNC_CLR=1, a low on clr_ni forces count_o to 0 at once, between edges, whatever the clock, load_ni, en_p_i and en_t_i are doing.
- R3: With ASYNC_CLR=0, a low on clr_ni leaves count_o unchanged until the next rising edge, which sets it to 0 regardless of load_ni and the enables. Feeding a decode of count 9 back to clr_ni gives the sequence 0..9, then 0.
- R4: With clr_ni high, a low load_ni at a rising edge copies data_i into count_o, whatever en_p_i and en_t_i are doing.
- R5: With clr_ni and load_ni high and both en_p_i and en_t_i high, each rising edge adds 1 to count_o. After 1111 the count wraps to 0000.
- R6: With clr_ni and load_ni high and either enable low, count_o holds its value across the edge.
- R7: carry_o is 1 exactly when count_o is all ones and en_t_i is 1. It does not depend on en_p_i, and it follows en_t_i without waiting for a clock edge.
- R8: Two stages form an 8-bit counter when they share the clock, clear and en_p_i, and the low stage's carry_o drives the high stage's en_t_i. The high stage's carry_o is then 1 only at count 255.
- R9: A change on load_ni, en_p_i or en_t_i between edges does not alter count_o until a rising edge samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| clr_ni | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLR |
| load_ni | input | 1 | Active-low synchronous parallel load |
| data_i | input | WIDTH | Preset value |
| en_p_i | input | 1 | Count enable that does not affect the carry |
| en_t_i | input | 1 | Carry-chain count enable; also gates carry_o |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | High when the count is at its maximum and en_t_i is high |

## Verification
The single stage is first free-run through more than one full cycle of 16 counts. This exposes wrap and carry faults. Load, hold and clear are then applied with the enables held in both states, which separates the priority order from the enable gating. Carry is probed with en_p_i low and en_t_i toggled, which checks that only one enable reaches it. A synchronous-clear stage with its count-9 decode fed back, and an 8-bit chain of two stages, show whether clear timing and the carry handoff at 15 and 255 are right. Control pulses placed between edges show whether anything acts before its edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_ZERO = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_ni,
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output cnt_op_e op_o
);
  // priority: clear > load > count > hold
  always_comb begin
    if (!clr_ni)                op_o = OP_ZERO;
    else if (!load_ni)          op_o = OP_LOAD;
    else if (en_p_i && en_t_i)  op_o = OP_INC;
    else                        op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_state.sv
module cnt_state
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] q_q, q_d;

  always_comb begin
    unique case (op_i)
      OP_ZERO: q_d = '0;
      OP_LOAD: q_d = data_i;
      OP_INC:  q_d = q_q + ONE;
      default: q_d = q_q;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) q_q <= '0;
        else         q_q <= q_d;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) q_q <= q_d;
    end
  endgenerate

  assign q_o = q_q;
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             en_t_i,
  output logic             carry_o
);
  // combinational terminal count; en_p deliberately not involved
  assign carry_o = en_t_i & (&q_i);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_p_i,
  input  logic             en_t_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] MAX = '1;

  cnt_op_e op;

  cnt_ctrl u_ctrl (
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .en_p_i (en_p_i),
    .en_t_i (en_t_i),
    .op_o   (op)
  );

  cnt_state #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_state (
    .clk_i (clk_i),
    .clr_ni(clr_ni),
    .op_i  (op),
    .data_i(data_i),
    .q_o   (count_o)
  );

  cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q_i    (count_o),
    .en_t_i (en_t_i),
    .carry_o(carry_o)
  );

  AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !load_ni |=> count_o == $past(data_i)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && en_p_i && en_t_i) |=> count_o == $past(count_o) + ONE); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && !(en_p_i && en_t_i)) |=> $stable(count_o)); // R6

  AST_CARRY_AT_MAX: assert property (@(posedge clk_i) disable iff (!clr_ni)
    carry_o |-> (count_o == MAX && en_t_i)); // R7
endmodule

// File: tb/sim_casc_counter.sv
`timescale 1ns/1ps
module sim_casc_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // single async stage
  logic       a_clr = 1'b0, a_ld = 1'b1, a_p = 1'b0, a_t = 1'b0;
  logic [3:0] a_d = '0, a_q;
  logic       a_co;
  casc_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u0 (
    .clk_i(clk), .clr_ni(a_clr), .load_ni(a_ld), .data_i(a_d),
    .en_p_i(a_p), .en_t_i(a_t), .count_o(a_q), .carry_o(a_co));

  // synchronous clear stage, decade by decoding 9
  logic       s_ext = 1'b0, s_ld = 1'b1, s_p = 1'b1;
  logic [3:0] s_q;
  logic       s_co, s_clr;
  assign s_clr = s_ext & ~(s_q == 4'd9);
  casc_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_sync (
    .clk_i(clk), .clr_ni(s_clr), .load_ni(s_ld), .data_i(4'd7),
    .en_p_i(s_p), .en_t_i(1'b1), .count_o(s_q), .carry_o(s_co));

  // two-stage 8-bit chain
  logic       c_clr = 1'b0, c_p = 1'b0;
  logic [3:0] c_lo, c_hi;
  logic       c_lo_co, c_hi_co;
  casc_counter u_lo (
    .clk_i(clk), .clr_ni(c_clr), .load_ni(1'b1), .data_i(4'd0),
    .en_p_i(c_p), .en_t_i(1'b1), .count_o(c_lo), .carry_o(c_lo_co));
  casc_counter u_hi (
    .clk_i(clk), .clr_ni(c_clr), .load_ni(1'b1), .data_i(4'd0),
    .en_p_i(c_p), .en_t_i(c_lo_co), .count_o(c_hi), .carry_o(c_hi_co));

  typedef struct {
    int    sel;
    int    exp;
    string tag;
  } item_t;
  item_t sb[$];

  int m_a = 0, m_s = 0, m_c = 0;

  function automatic int actual(int sel);
    case (sel)
      0: return int'(a_q);
      1: return int'(a_co);
      2: return int'(s_q);
      3: return int'({c_hi, c_lo});
      default: return int'(c_hi_co);
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compares queued expectations shortly after each edge
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, actual(it.sel), it.exp);
    end
  end

  // driver step: one edge, update models, push expectations, return at negedge
  task automatic tick(string tag);
    logic s_clr_m;
    @(posedge clk);
    if (!a_clr)          m_a = 0;
    else if (!a_ld)      m_a = int'(a_d);
    else if (a_p && a_t) m_a = (m_a + 1) % 16;
    s_clr_m = s_ext && (m_s != 9);
    if (!s_clr_m)        m_s = 0;
    else if (!s_ld)      m_s = 7;
    else if (s_p)        m_s = (m_s + 1) % 16;
    if (!c_clr)          m_c = 0;
    else if (c_p)        m_c = (m_c + 1) % 256;
    sb.push_back('{0, m_a, {tag, " count"}});
    sb.push_back('{1, (m_a == 15 && a_t) ? 1 : 0, {tag, " carry R7"}});
    sb.push_back('{2, m_s, {tag, " sync R3"}});
    sb.push_back('{3, m_c, {tag, " chain R8"}});
    sb.push_back('{4, (m_c == 255) ? 1 : 0, {tag, " chain carry R8"}});
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    chk("R2 reset count", int'(a_q), 0);
    chk("R2 reset carry", int'(a_co), 0);
    tick("R2 held clear");
    a_clr = 1'b1; s_ext = 1'b1; c_clr = 1'b1; c_p = 1'b1;
    a_p = 1'b1; a_t = 1'b1;
    for (int i = 0; i < 20; i++) tick("R5 R1 run");
    // load overrides disabled enables
    a_p = 1'b0; a_t = 1'b0; a_ld = 1'b0; a_d = 4'hE;
    tick("R4 load");
    a_ld = 1'b1;
    a_t = 1'b1;
    tick("R6 hold p low");
    a_ld = 1'b0; a_d = 4'hF;
    tick("R4 load max");
    a_ld = 1'b1;
    #1 chk("R7 carry with p low", int'(a_co), 1);
    a_t = 1'b0;
    #0.2 chk("R7 carry follows t", int'(a_co), 0);
    a_p = 1'b1;
    tick("R6 hold t low");
    // control pulse between edges
    a_ld = 1'b0; a_d = 4'h5;
    #0.5 chk("R9 no load before edge", int'(a_q), 15);
    a_ld = 1'b1;
    tick("R9 pulse ignored");
    a_t = 1'b1;
    for (int i = 0; i < 3; i++) tick("R5 wrap");
    // async clear between edges beats load and enables
    a_ld = 1'b0; a_d = 4'hA; a_clr = 1'b0;
    #0.5 chk("R2 async clear immediate", int'(a_q), 0);
    tick("R2 clear over load");
    a_clr = 1'b1; a_ld = 1'b1;
    // sync clear waits for the edge, beats load and enable
    for (int i = 0; i < 4; i++) tick("R3 decade");
    s_ext = 1'b0; s_ld = 1'b0; s_p = 1'b0;
    #0.5 chk("R3 sync clear waits", int'(s_q), m_s);
    tick("R3 sync clear");
    s_ext = 1'b1;
    tick("R4 sync load");
    s_ld = 1'b1; s_p = 1'b1;
    for (int i = 0; i < 260; i++) tick("R8 chain");
    @(posedge clk); #2;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule